// File: doc/BRIEF.md
# Text screen character writer

This block turns a byte stream of ASCII characters into write strobes for a character memory that holds a text screen of `COLS` columns by `ROWS` rows (80 by 60 unless overridden; a 16 by 4 panel works just as well). It keeps a cursor. Each printable character is stored at the cursor cell, and the cursor then moves on. Four control codes move the cursor or wipe the screen. The memory, the font lookup and the display scan logic sit outside and only consume the write port.

Characters arrive on a valid/ready handshake. A character is taken in any cycle where valid and ready are both high. Printable characters produce exactly one write in the following cycle. The clear-screen code starts a sweep that writes a space to every cell, one cell per cycle, in ascending address order. Input ready stays low for the whole sweep. After the sweep the cursor is at the top-left cell. The cursor wraps from the last column to the next row, and from the last row back to row 0. The screen is never scrolled.

Top module: `glyph_writer`

## Requirements
- R1: A byte in 0x20..0x7E that is accepted makes `wr_en_o` high in the next cycle, with `wr_data_o` equal to that byte and `wr_addr_o` equal to row*COLS+col of the cursor as it was before acceptance.
- R2: After a printable write the column advances by one. From column COLS-1 it goes to column 0 of the next row.
- R3: Carriage return (0x0D) sets the column to 0, leaves the row unchanged and writes nothing.
- R4: Line feed (0x0A) moves the cursor to the next row, keeps the column and writes nothing.
- R5: Advancing past row ROWS-1, whether by line feed or by wrapping from the last cell, lands on row 0. No other cell is rewritten.
- R6: Home (0x01) puts the cursor at column 0, row 0 and writes nothing.
- R7: Clear screen (0x0C) drops `chr_ready_o` in the cycle after acceptance. During the next COLS*ROWS cycles the block writes 0x20 to addresses 0, 1, ..., COLS*ROWS-1, one per cycle. `chr_ready_o` rises in the cycle of the last write.
- R8: After the sweep the cursor is at column 0, row 0. A character held on the input during the sweep is taken as soon as ready rises and is written at address 0.
- R9: Any other byte (control codes other than the four above, 0x7F and 0x80..0xFF) writes nothing and leaves the cursor unchanged.
- R10: After reset `chr_ready_o` is high, `wr_en_o` is low and the cursor is at column 0, row 0.
- R11: `wr_en_o` is high only in the cycle after a printable byte is accepted or during a sweep. The total number of writes equals the printable bytes accepted plus COLS*ROWS per clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chr_valid_i | input | 1 | Input byte is present |
| chr_data_i | input | 8 | Input ASCII byte |
| chr_ready_o | output | 1 | Block can take a byte this cycle |
| wr_en_o | output | 1 | Character memory write strobe |
| wr_addr_o | output | $clog2(COLS*ROWS) | Linear cell address, row*COLS+col |
| wr_data_o | output | 8 | Character code to store |

## Verification
The end of a clear sweep can meet the arrival of a new character. The cycle that carries the last space write is also the cycle in which ready rises and a waiting byte is taken, and that byte must land at address 0 because the cursor homes on the same edge. The bench provokes this by holding a printable byte on the input for the whole sweep. It then checks every sweep address, the exact cycle in which ready returns, and that the held byte is written once, at address 0, immediately after the last space. The second meeting point is a printable write to the final cell, where the column and row wrap together. The bench judges it by the address of the next write, which must be 0.

// File: rtl/glyph_writer_pkg.sv
package glyph_writer_pkg;

    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_PRINT = 3'd1,
        KIND_CR    = 3'd2,
        KIND_LF    = 3'd3,
        KIND_CLEAR = 3'd4,
        KIND_HOME  = 3'd5
    } char_kind_e;

    localparam logic [7:0] CODE_CR    = 8'h0D;
    localparam logic [7:0] CODE_LF    = 8'h0A;
    localparam logic [7:0] CODE_CLEAR = 8'h0C;
    localparam logic [7:0] CODE_HOME  = 8'h01;
    localparam logic [7:0] CODE_SPACE = 8'h20;
    localparam logic [7:0] PRINT_LO   = 8'h20;
    localparam logic [7:0] PRINT_HI   = 8'h7E;

endpackage

// File: rtl/gw_classify.sv
module gw_classify
    import glyph_writer_pkg::*;
(
    input  logic [7:0] code_i,
    output char_kind_e kind_o
);

    always_comb begin
        if (code_i >= PRINT_LO && code_i <= PRINT_HI) begin
            kind_o = KIND_PRINT;
        end else begin
            unique case (code_i)
                CODE_CR:    kind_o = KIND_CR;
                CODE_LF:    kind_o = KIND_LF;
                CODE_CLEAR: kind_o = KIND_CLEAR;
                CODE_HOME:  kind_o = KIND_HOME;
                default:    kind_o = KIND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gw_cursor.sv
module gw_cursor #(
    parameter int COLS = 80,
    parameter int ROWS = 60,
    localparam int CELLS  = COLS * ROWS,
    localparam int ADDR_W = $clog2(CELLS),
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    input  logic              cr_i,
    input  logic              lf_i,
    input  logic              home_i,
    output logic [ADDR_W-1:0] lin_o
);

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(CELLS - 1);
    localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(COLS);
    localparam logic [ADDR_W-1:0] TOP_BASE  = ADDR_W'((ROWS - 1) * COLS);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [ADDR_W-1:0] lin;
    } cursor_t;

    cursor_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (home_i) begin
            cur_d = '0;
        end else if (adv_i) begin
            if (cur_q.col == LAST_COL) begin
                cur_d.col = '0;
                cur_d.row = (cur_q.row == LAST_ROW) ? '0 : cur_q.row + 1'b1;
            end else begin
                cur_d.col = cur_q.col + 1'b1;
            end
            cur_d.lin = (cur_q.lin == LAST_CELL) ? '0 : cur_q.lin + 1'b1;
        end else if (cr_i) begin
            cur_d.col = '0;
            cur_d.lin = cur_q.lin - ADDR_W'(cur_q.col);
        end else if (lf_i) begin
            if (cur_q.row == LAST_ROW) begin
                cur_d.row = '0;
                cur_d.lin = cur_q.lin - TOP_BASE;
            end else begin
                cur_d.row = cur_q.row + 1'b1;
                cur_d.lin = cur_q.lin + STRIDE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign lin_o = cur_q.lin;

endmodule

// File: rtl/gw_sweep.sv
module gw_sweep #(
    parameter int CELLS = 4800,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(CELLS - 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] idx;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        if (sw_q.busy) begin
            if (sw_q.idx == LAST_IDX) begin
                sw_d.busy = 1'b0;
                sw_d.idx  = '0;
            end else begin
                sw_d.idx = sw_q.idx + 1'b1;
            end
        end else if (start_i) begin
            sw_d.busy = 1'b1;
            sw_d.idx  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign busy_o = sw_q.busy;
    assign idx_o  = sw_q.idx;
    assign last_o = sw_q.busy && (sw_q.idx == LAST_IDX);

endmodule

// File: rtl/glyph_writer.sv
module glyph_writer
    import glyph_writer_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 60,
    localparam int CELLS  = COLS * ROWS,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              chr_valid_i,
    input  logic [7:0]        chr_data_i,
    output logic              chr_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wport_t;

    char_kind_e        kind;
    logic              accept;
    logic              sweep_busy;
    logic              sweep_last;
    logic [ADDR_W-1:0] sweep_idx;
    logic [ADDR_W-1:0] cur_lin;
    wport_t            wp_d, wp_q;

    assign chr_ready_o = !sweep_busy;
    assign accept      = chr_valid_i && chr_ready_o;

    gw_classify u_classify (
        .code_i (chr_data_i),
        .kind_o (kind)
    );

    gw_cursor #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_cursor (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (accept && (kind == KIND_PRINT)),
        .cr_i   (accept && (kind == KIND_CR)),
        .lf_i   (accept && (kind == KIND_LF)),
        .home_i ((accept && (kind == KIND_HOME)) || sweep_last),
        .lin_o  (cur_lin)
    );

    gw_sweep #(
        .CELLS (CELLS)
    ) u_sweep (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (accept && (kind == KIND_CLEAR)),
        .busy_o  (sweep_busy),
        .idx_o   (sweep_idx),
        .last_o  (sweep_last)
    );

    always_comb begin
        wp_d = '0;
        if (sweep_busy) begin
            wp_d.en   = 1'b1;
            wp_d.addr = sweep_idx;
            wp_d.data = CODE_SPACE;
        end else if (accept && (kind == KIND_PRINT)) begin
            wp_d.en   = 1'b1;
            wp_d.addr = cur_lin;
            wp_d.data = chr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wp_q <= '0;
        end else begin
            wp_q <= wp_d;
        end
    end

    assign wr_en_o   = wp_q.en;
    assign wr_addr_o = wp_q.addr;
    assign wr_data_o = wp_q.data;

endmodule

// File: rtl/glyph_writer_chk.sv
module glyph_writer_chk #(
    parameter int COLS = 80,
    parameter int ROWS = 60,
    localparam int CELLS  = COLS * ROWS,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              chr_valid_i,
    input logic [7:0]        chr_data_i,
    input logic              chr_ready_o,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [7:0]        wr_data_o
);

    logic take;
    logic printable;

    assign take      = chr_valid_i && chr_ready_o;
    assign printable = (chr_data_i >= 8'h20) && (chr_data_i <= 8'h7E);

    assert_print_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && printable) |=> (wr_en_o && (wr_data_o == $past(chr_data_i))));

    assert_ctrl_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && !printable && (chr_data_i != 8'h0C)) |=> !wr_en_o);

    assert_clear_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && (chr_data_i == 8'h0C)) |=> !chr_ready_o);

    assert_sweep_space_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chr_ready_o |=> (wr_en_o && (wr_data_o == 8'h20)));

    assert_sweep_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && !chr_ready_o) |=> (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1)));

    assert_write_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> ($past(take && printable) || $past(!chr_ready_o)));

endmodule

bind glyph_writer glyph_writer_chk #(
    .COLS (COLS),
    .ROWS (ROWS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chr_valid_i (chr_valid_i),
    .chr_data_i  (chr_data_i),
    .chr_ready_o (chr_ready_o),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
);

// File: tb/glyph_writer_tb.sv
module glyph_writer_tb;

    localparam int COLS  = 16;
    localparam int ROWS  = 4;
    localparam int CELLS = COLS * ROWS;
    localparam int AW    = $clog2(CELLS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chr_valid_i = 1'b0;
    logic [7:0]    chr_data_i = 8'h00;
    logic          chr_ready_o;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [7:0]    wr_data_o;

    int n_chk = 0;
    int n_fail = 0;
    int m_col = 0;
    int m_row = 0;
    int exp_writes = 0;
    int seen_writes = 0;

    always #10 clk = ~clk;

    glyph_writer #(.COLS(COLS), .ROWS(ROWS)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .chr_valid_i (chr_valid_i),
        .chr_data_i  (chr_data_i),
        .chr_ready_o (chr_ready_o),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en_o) seen_writes <= seen_writes + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Sends one byte (not clear) and checks the write that must or must not follow.
    task automatic send(input logic [7:0] b, input string req);
        bit print;
        int ea;
        while (!chr_ready_o) @(negedge clk);
        print = (b >= 8'h20) && (b <= 8'h7E);
        ea = m_row * COLS + m_col;
        chr_valid_i = 1'b1;
        chr_data_i  = b;
        @(posedge clk);
        @(negedge clk);
        chr_valid_i = 1'b0;
        if (print) begin
            check(wr_en_o === 1'b1 && int'(wr_addr_o) == ea && wr_data_o == b,
                  req, "print write address", wr_en_o ? int'(wr_addr_o) : -1, ea);
            exp_writes++;
            m_col++;
            if (m_col == COLS) begin
                m_col = 0;
                m_row = (m_row + 1) % ROWS;
            end
        end else begin
            check(wr_en_o === 1'b0, req, "control byte write strobe", int'(wr_en_o), 0);
            if (b == 8'h0D) m_col = 0;
            else if (b == 8'h0A) m_row = (m_row + 1) % ROWS;
            else if (b == 8'h01) begin m_col = 0; m_row = 0; end
        end
    endtask

    task automatic do_clear(input bit hold, input logic [7:0] hb);
        int bad_addr = 0;
        int bad_rdy = 0;
        while (!chr_ready_o) @(negedge clk);
        chr_valid_i = 1'b1;
        chr_data_i  = 8'h0C;
        @(posedge clk);
        @(negedge clk);
        chr_valid_i = hold;
        chr_data_i  = hb;
        check(chr_ready_o === 1'b0 && wr_en_o === 1'b0, "R7", "ready after clear accept",
              int'(chr_ready_o), 0);
        for (int k = 0; k < CELLS; k++) begin
            @(negedge clk);
            if (!(wr_en_o === 1'b1 && int'(wr_addr_o) == k && wr_data_o == 8'h20)) bad_addr++;
            if (chr_ready_o !== (k == CELLS - 1)) bad_rdy++;
        end
        check(bad_addr == 0, "R7", "sweep cells wrong", bad_addr, 0);
        check(bad_rdy == 0, "R7", "sweep ready cycles wrong", bad_rdy, 0);
        exp_writes += CELLS;
        m_col = 0;
        m_row = 0;
        if (hold) begin
            @(negedge clk);
            chr_valid_i = 1'b0;
            check(wr_en_o === 1'b1 && wr_addr_o == '0 && wr_data_o == hb, "R8",
                  "held byte after sweep", wr_en_o ? int'(wr_addr_o) : -1, 0);
            exp_writes++;
            m_col = 1;
        end
    endtask

    task automatic t_reset();
        check(chr_ready_o === 1'b1, "R10", "ready after reset", int'(chr_ready_o), 1);
        check(wr_en_o === 1'b0, "R10", "write strobe after reset", int'(wr_en_o), 0);
        send("A", "R10");
    endtask

    task automatic t_print();
        send("H", "R1");
        send("i", "R1");
        send("!", "R1");
    endtask

    task automatic t_cr_lf();
        send(8'h0D, "R3");
        send("c", "R3");
        send(8'h0A, "R4");
        send("d", "R4");
    endtask

    task automatic t_col_wrap();
        for (int i = 0; i < COLS; i++) send(8'h41 + 8'(i), "R2");
    endtask

    task automatic t_row_wrap();
        send(8'h0A, "R5");
        send(8'h0A, "R5");
        send(8'h0A, "R5");
        send("e", "R5");
        send(8'h01, "R6");
        for (int i = 0; i < ROWS - 1; i++) send(8'h0A, "R5");
        for (int i = 0; i < COLS + 1; i++) send(8'h61 + 8'(i % 26), "R5");
    endtask

    task automatic t_home();
        send("x", "R6");
        send(8'h0A, "R6");
        send(8'h01, "R6");
        send("y", "R6");
    endtask

    task automatic t_ignore();
        send(8'h00, "R9");
        send(8'h09, "R9");
        send(8'h1B, "R9");
        send(8'h0E, "R9");
        send(8'h7F, "R9");
        send(8'h80, "R9");
        send(8'hFF, "R9");
        send("q", "R9");
    endtask

    task automatic t_clear();
        send("m", "R7");
        do_clear(1'b0, 8'h00);
        send("n", "R8");
        send("o", "R8");
        do_clear(1'b1, "Z");
        send("p", "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_print();
        t_cr_lf();
        t_col_wrap();
        t_row_wrap();
        t_home();
        t_ignore();
        t_clear();
        repeat (2) @(negedge clk);
        check(seen_writes == exp_writes, "R11", "total write count", seen_writes, exp_writes);
        summary();
    end

endmodule